// File: doc/BRIEF.md
# Signed 32-by-16 Divider with Microcode-Accurate Timing

This block divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor. It produces a packed 32-bit result: the signed quotient sits in the low half and the signed remainder in the high half. It also sets three condition flags: overflow, negative and zero. Alongside the arithmetic it reports how many clock cycles an older microcoded processor would spend on the same divide, and it raises its completion pulse exactly that many cycles after it accepts the operands. A cycle-accurate system model can therefore drop it in place of the original instruction timing.

Internally the divisor is sign-extended and both operands are reduced to magnitudes. A single compare then finds out whether the magnitude quotient can fit in 15 bits. If it cannot, the operation ends early with the overflow flag set and the destination left as it was. Otherwise a restoring shift-subtract engine produces one quotient bit per clock, and the signs are applied at the end. The cycle count depends on two things: the signs of the operands and the number of cleared bits in the upper fifteen bits of the magnitude quotient.

A zero divisor does not start a divide. It produces a single-cycle trap pulse instead.

Operands enter through a valid/ready handshake. The block holds `in_ready` low for the whole operation, so nothing can be queued behind a divide in progress. The result side has no back-pressure. `done` is a one-cycle pulse, and the result, flags and count registers hold their values until the next completed divide.

Top module: `sdiv_timed`

## Requirements
- R1: After reset, `res_data`, `cycles` and all three flags read zero, `done` and `div_trap` are low, and `in_ready` is high.
- R2: Operands are taken on a rising edge where `in_valid` and `in_ready` are both high. For a divide with a non-zero divisor, `in_ready` stays low from that edge until the edge that raises `done`, and is high again while `done` is high. Any `in_valid` seen while `in_ready` is low is ignored: it causes no trap, no extra `done` and no change to the result.
- R3: When the magnitude quotient is at most 32767, `res_data[15:0]` holds the truncated signed quotient and `res_data[31:16]` holds the remainder. The divisor is treated as sign-extended. The remainder carries the dividend's sign, so that quotient times divisor plus remainder equals the dividend.
- R4: On a divide without overflow, `flag_v` is 0, `flag_n` equals bit 15 of the signed quotient, and `flag_z` is 1 exactly when the 16-bit quotient is zero.
- R5: When the magnitude quotient exceeds 32767, `flag_v` is 1 and `res_data` keeps its previous value. `flag_n` is bit 15 of the dividend's magnitude, and `flag_z` is 1 exactly when bits 15:0 of that magnitude are all zero.
- R6: On a divide without overflow, `cycles` is the sum of these terms: 116 base cycles; plus 2 if the dividend is negative; plus 2 for each zero among bits 15:1 of the magnitude quotient; plus a final term of 2 if the divisor is negative, else 4 if the dividend is negative, else 0.
- R7: On overflow, `cycles` is 12, or 14 when the dividend is negative.
- R8: A zero divisor raises `div_trap` for exactly the one cycle that follows the accepting edge. It produces no `done`, leaves `res_data`, `cycles` and the flags unchanged, and keeps `in_ready` high.
- R9: `done` is high for exactly one cycle. That cycle begins at the C-th rising edge after the accepting edge, where C is the count shown on `cycles` in that same cycle. `cycles` then holds C until the next completed divide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands offered this cycle |
| in_ready | output | 1 | Block idle and able to take operands |
| in_dividend | input | 32 | Two's-complement dividend |
| in_divisor | input | 16 | Two's-complement divisor |
| res_data | output | 32 | Remainder in bits 31:16, quotient in bits 15:0 |
| flag_v | output | 1 | Quotient did not fit in 16 signed bits |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| done | output | 1 | One-cycle completion pulse |
| div_trap | output | 1 | One-cycle pulse for a zero divisor |
| cycles | output | 8 | Emulated cycle count of the last completed divide |

## Verification
The directed tests cover the corner cases below.

- **Operand signs.** All four sign combinations are run. A design that put the wrong sign on the remainder would fail the negative-dividend cases. A design that chose the wrong final timing term would be off by two or four cycles when only one operand is negative.
- **Overflow boundary.** A magnitude quotient of exactly 32767 is run next to one of 32768. A design that compared off by one would either clobber the destination or report overflow for a legal result.
- **Overflow flags.** The most negative dividend divided by minus one is run. A design that took the flags from the quotient instead of the dividend's magnitude would show the wrong zero flag.
- **Zero divisor and busy strobes.** The bench applies a zero divisor while idle. It also drives strobes, including ones with a zero divisor, while a divide is running. A design that accepted those strobes would trap, emit a second `done`, or overwrite the result.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  // Controller phases
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOP,
    ST_WAIT
  } sdiv_state_e;

  // Facts about an accepted operation that steer the cost and the sign fix-up
  typedef struct packed {
    logic neg_a;   // dividend negative
    logic neg_b;   // divisor negative
    logic ovf;     // magnitude quotient too large
  } op_info_t;

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int DW = 32,
  parameter int VW = 16
) (
  input  logic [DW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic          a_neg,
  output logic          b_neg,
  output logic [VW-1:0] b_mag,
  output logic [VW-1:0] rem_seed,
  output logic [VW-2:0] low_bits,
  output logic [VW-1:0] mag_lo,
  output logic          q_ovf,
  output logic          z_div
);
  localparam int HW = DW - VW + 1;  // dividend bits above the quotient field

  logic [DW-1:0] a_mag;

  assign a_neg = dividend[DW-1];
  assign b_neg = divisor[VW-1];
  assign a_mag = a_neg ? (~dividend) + DW'(1) : dividend;
  assign b_mag = b_neg ? (~divisor) + VW'(1) : divisor;
  assign z_div = (divisor == '0);

  // The quotient fits in VW-1 bits exactly when the top HW bits of the
  // dividend magnitude are below the divisor magnitude.
  assign q_ovf = (a_mag[DW-1:VW-1] >= {{(HW-VW){1'b0}}, b_mag});

  // Partial remainder seed and the bits left to shift in
  assign rem_seed = a_mag[DW-2:VW-1];
  assign low_bits = a_mag[VW-2:0];
  assign mag_lo   = a_mag[VW-1:0];

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int VW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [VW-1:0] rem_init,
  input  logic [VW-2:0] low_bits,
  input  logic [VW-1:0] dvs_mag,
  output logic [VW-1:0] quo_mag,
  output logic [VW-1:0] rem_mag,
  output logic          fin
);
  localparam int SW = VW - 1;       // quotient bits produced
  localparam int KW = $clog2(VW);   // step counter width

  logic [VW-1:0] rem_q;
  logic [SW-1:0] shf_q;  // dividend bits out at the top, quotient bits in at the bottom
  logic [VW-1:0] dvs_q;
  logic [KW-1:0] left_q;
  logic          run_q;

  logic [VW:0] cand;
  logic [VW:0] diff;
  logic        take;

  always_comb begin
    cand = {rem_q, shf_q[SW-1]};
    diff = cand - {1'b0, dvs_q};
    take = (cand >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      shf_q  <= '0;
      dvs_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rem_q  <= rem_init;
        shf_q  <= low_bits;
        dvs_q  <= dvs_mag;
        left_q <= KW'(SW);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= take ? diff[VW-1:0] : cand[VW-1:0];
        shf_q  <= {shf_q[SW-2:0], take};
        left_q <= left_q - KW'(1);
        if (left_q == KW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign quo_mag = {1'b0, shf_q};
  assign rem_mag = rem_q;

endmodule

// File: rtl/sdiv_cost.sv
module sdiv_cost
  import sdiv_pkg::*;
#(
  parameter int VW         = 16,
  parameter int CW         = 8,
  parameter int C_BASE     = 12,
  parameter int C_NEGA     = 2,
  parameter int C_ZBIT     = 2,
  parameter int C_TAIL     = 104,
  parameter int C_NEGB_END = 2,
  parameter int C_NEGA_END = 4
) (
  input  op_info_t      info,
  input  logic [VW-2:0] q_hi,   // magnitude quotient bits VW-1..1
  output logic [CW-1:0] cost
);
  int total;

  always_comb begin
    total = C_BASE;
    if (info.neg_a) total = total + C_NEGA;
    if (!info.ovf) begin
      for (int i = 0; i < VW - 1; i++) begin
        if (!q_hi[i]) total = total + C_ZBIT;
      end
      total = total + C_TAIL;
      if (info.neg_b)      total = total + C_NEGB_END;
      else if (info.neg_a) total = total + C_NEGA_END;
    end
    cost = CW'(total);
  end

endmodule

// File: rtl/sdiv_timed.sv
module sdiv_timed
  import sdiv_pkg::*;
#(
  parameter int DW         = 32,
  parameter int VW         = 16,
  parameter int CW         = 8,
  parameter int C_BASE     = 12,
  parameter int C_NEGA     = 2,
  parameter int C_ZBIT     = 2,
  parameter int C_TAIL     = 104,
  parameter int C_NEGB_END = 2,
  parameter int C_NEGA_END = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_dividend,
  input  logic [VW-1:0] in_divisor,
  output logic [DW-1:0] res_data,
  output logic          flag_v,
  output logic          flag_n,
  output logic          flag_z,
  output logic          done,
  output logic          div_trap,
  output logic [CW-1:0] cycles
);

  // Operand preparation
  logic          a_neg, b_neg, q_ovf, z_div;
  logic [VW-1:0] b_mag, rem_seed, mag_lo;
  logic [VW-2:0] low_bits;

  sdiv_prep #(.DW(DW), .VW(VW)) u_prep (
    .dividend (in_dividend),
    .divisor  (in_divisor),
    .a_neg    (a_neg),
    .b_neg    (b_neg),
    .b_mag    (b_mag),
    .rem_seed (rem_seed),
    .low_bits (low_bits),
    .mag_lo   (mag_lo),
    .q_ovf    (q_ovf),
    .z_div    (z_div)
  );

  // Control state
  sdiv_state_e   state_q;
  op_info_t      info_q, info_d;
  logic [VW-1:0] mag_lo_q;
  logic [CW-1:0] tick_q;

  logic accept, go_core, publish;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign go_core  = accept && !z_div && !q_ovf;
  assign info_d   = '{neg_a: a_neg, neg_b: b_neg, ovf: q_ovf};

  // Iterative magnitude engine
  logic [VW-1:0] quo_mag, rem_mag;
  logic          core_fin;

  sdiv_core #(.VW(VW)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (go_core),
    .rem_init (rem_seed),
    .low_bits (low_bits),
    .dvs_mag  (b_mag),
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .fin      (core_fin)
  );

  // Emulated cycle cost
  logic [CW-1:0] cost;

  sdiv_cost #(
    .VW(VW), .CW(CW), .C_BASE(C_BASE), .C_NEGA(C_NEGA), .C_ZBIT(C_ZBIT),
    .C_TAIL(C_TAIL), .C_NEGB_END(C_NEGB_END), .C_NEGA_END(C_NEGA_END)
  ) u_cost (
    .info (info_q),
    .q_hi (quo_mag[VW-1:1]),
    .cost (cost)
  );

  // Sign restoration
  logic [VW-1:0] quo_s, rem_s;

  always_comb begin
    quo_s = (info_q.neg_a ^ info_q.neg_b) ? (~quo_mag) + VW'(1) : quo_mag;
    rem_s = info_q.neg_a ? (~rem_mag) + VW'(1) : rem_mag;
  end

  // The count is complete at the edge that ends cycle number `cost`
  assign publish = (state_q == ST_WAIT) && ((tick_q + CW'(1)) == cost);

  // Output registers
  logic [DW-1:0] res_q;
  logic          v_q, n_q, z_q, done_q, trap_q;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      info_q   <= '0;
      mag_lo_q <= '0;
      tick_q   <= '0;
      res_q    <= '0;
      v_q      <= 1'b0;
      n_q      <= 1'b0;
      z_q      <= 1'b0;
      done_q   <= 1'b0;
      trap_q   <= 1'b0;
      cyc_q    <= '0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (z_div) begin
              trap_q <= 1'b1;
            end else begin
              info_q   <= info_d;
              mag_lo_q <= mag_lo;
              tick_q   <= '0;
              state_q  <= q_ovf ? ST_WAIT : ST_LOOP;
            end
          end
        end
        ST_LOOP: begin
          tick_q <= tick_q + CW'(1);
          if (core_fin) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          tick_q <= tick_q + CW'(1);
          if (publish) begin
            done_q  <= 1'b1;
            cyc_q   <= cost;
            v_q     <= info_q.ovf;
            state_q <= ST_IDLE;
            if (info_q.ovf) begin
              n_q <= mag_lo_q[VW-1];
              z_q <= (mag_lo_q == '0);
            end else begin
              res_q <= {rem_s, quo_s};
              n_q   <= quo_s[VW-1];
              z_q   <= (quo_s == '0);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign res_data = res_q;
  assign flag_v   = v_q;
  assign flag_n   = n_q;
  assign flag_z   = z_q;
  assign done     = done_q;
  assign div_trap = trap_q;
  assign cycles   = cyc_q;

endmodule

// File: rtl/sdiv_timed_chk.sv
module sdiv_timed_chk #(
  parameter int DW     = 32,
  parameter int VW     = 16,
  parameter int CW     = 8,
  parameter int C_BASE = 12,
  parameter int C_NEGA = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic [DW-1:0] res_data,
  input logic          flag_v,
  input logic          flag_n,
  input logic          flag_z,
  input logic          done,
  input logic          div_trap,
  input logic [CW-1:0] cycles
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  ready_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R8
  trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_trap |-> (!done && in_ready && $stable(res_data) && $stable(cycles)
                  && $stable(flag_v) && $stable(flag_n) && $stable(flag_z)));

  // R5
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v) |-> $stable(res_data));

  // R4
  quotient_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_v) |-> (flag_n == res_data[VW-1]
                           && flag_z == (res_data[VW-1:0] == '0)));

  // R7
  overflow_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v) |-> (int'(cycles) == C_BASE || int'(cycles) == C_BASE + C_NEGA));

endmodule

bind sdiv_timed sdiv_timed_chk #(
  .DW(DW), .VW(VW), .CW(CW), .C_BASE(C_BASE), .C_NEGA(C_NEGA)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .res_data (res_data),
  .flag_v   (flag_v),
  .flag_n   (flag_n),
  .flag_z   (flag_z),
  .done     (done),
  .div_trap (div_trap),
  .cycles   (cycles)
);

// File: tb/sim_sdiv_timed.sv
module sim_sdiv_timed;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] dvd = '0;
  logic [15:0] dvs = '0;
  logic        in_ready, flag_v, flag_n, flag_z, done, div_trap;
  logic [31:0] res_data;
  logic [7:0]  cycles;

  sdiv_timed u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(dvd), .in_divisor(dvs), .res_data(res_data),
    .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .done(done),
    .div_trap(div_trap), .cycles(cycles)
  );

  always #10 clk = ~clk;  // 50 MHz

  int n_chk = 0;
  int n_err = 0;

  // Last published state, tracked from the requirements
  logic [31:0] last_res = '0;
  logic        last_v = 1'b0, last_n = 1'b0, last_z = 1'b0;
  logic [7:0]  last_cyc = '0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference built on integer division
  task automatic model(input logic [31:0] a, input logic [15:0] b,
                       output logic [31:0] e_res, output logic e_v,
                       output logic e_n, output logic e_z, output int e_cyc);
    longint sa, sb, ma, mb, q, r, qs;
    int c;
    sa = longint'(signed'(a));
    sb = longint'(signed'(b));
    ma = (sa < 0) ? -sa : sa;
    mb = (sb < 0) ? -sb : sb;
    q  = ma / mb;
    c  = 12 + ((sa < 0) ? 2 : 0);
    if (q > 32767) begin
      e_v = 1'b1; e_res = last_res; e_n = ma[15]; e_z = (ma[15:0] == 16'h0);
    end else begin
      r  = sa % sb;
      qs = ((sa < 0) != (sb < 0)) ? -q : q;
      e_res = {r[15:0], qs[15:0]};
      e_v = 1'b0; e_n = qs[15]; e_z = (qs[15:0] == 16'h0);
      for (int i = 1; i < 16; i++) if (!q[i]) c += 2;
      c += 104;
      if (sb < 0) c += 2;
      else if (sa < 0) c += 4;
    end
    e_cyc = c;
  endtask

  // One divide; with noise set, strobes (zero divisor) are driven while busy
  task automatic run_div(input string name, input logic [31:0] a,
                         input logic [15:0] b, input bit noise);
    logic [31:0] e_res;
    logic e_v, e_n, e_z;
    int e_cyc, n;
    bit trap_seen, extra_done;
    model(a, b, e_res, e_v, e_n, e_z, e_cyc);
    @(negedge clk);
    dvd = a; dvs = b; in_valid = 1'b1;
    @(negedge clk);                 // accepting edge has passed
    in_valid = noise;
    if (noise) begin dvd = 32'h0000_1234; dvs = 16'h0000; end
    chk("R2", {name, " ready low while busy"}, in_ready, 0);
    n = 0; trap_seen = 0;
    while (done !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
      if (div_trap) trap_seen = 1;
      if (n == 6) in_valid = 1'b0;
    end
    chk("R9", {name, " edges to done"}, n, e_cyc);
    chk("R2", {name, " ready with done"}, in_ready, 1);
    if (e_v) begin
      chk("R7", {name, " cycles"}, cycles, e_cyc);
      chk("R5", {name, " result held"}, res_data, e_res);
      chk("R5", {name, " flags vnz"}, {flag_v, flag_n, flag_z}, {e_v, e_n, e_z});
    end else begin
      chk("R6", {name, " cycles"}, cycles, e_cyc);
      chk("R3", {name, " result"}, res_data, e_res);
      chk("R4", {name, " flags vnz"}, {flag_v, flag_n, flag_z}, {e_v, e_n, e_z});
    end
    @(negedge clk);
    chk("R9", {name, " done one cycle"}, done, 0);
    chk("R9", {name, " cycles held"}, cycles, e_cyc);
    last_res = e_res; last_v = e_v; last_n = e_n; last_z = e_z; last_cyc = 8'(e_cyc);
    if (noise) begin
      chk("R2", {name, " no trap while busy"}, trap_seen, 0);
      extra_done = 0;
      repeat (160) begin
        @(negedge clk);
        if (done) extra_done = 1;
      end
      chk("R2", {name, " no second done"}, extra_done, 0);
      chk("R2", {name, " result kept"}, res_data, e_res);
    end
  endtask

  task automatic run_trap(input logic [31:0] a);
    bit seen_done;
    @(negedge clk);
    dvd = a; dvs = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "trap after accept", div_trap, 1);
    chk("R8", "ready during trap", in_ready, 1);
    @(negedge clk);
    chk("R8", "trap one cycle", div_trap, 0);
    seen_done = 0;
    repeat (160) begin
      @(negedge clk);
      if (done) seen_done = 1;
    end
    chk("R8", "no done on trap", seen_done, 0);
    chk("R8", "result kept", res_data, last_res);
    chk("R8", "flags kept", {flag_v, flag_n, flag_z}, {last_v, last_n, last_z});
    chk("R8", "cycles kept", cycles, last_cyc);
  endtask

  task automatic run_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset result", res_data, 0);
    chk("R1", "reset cycles", cycles, 0);
    chk("R1", "reset flags", {flag_v, flag_n, flag_z}, 0);
    chk("R1", "reset pulses", {done, div_trap}, 0);
    chk("R1", "reset ready", in_ready, 1);
  endtask

  initial begin
    run_reset();
    run_div("pos/pos", 32'd100000, 16'd7, 0);
    run_div("neg/pos", -32'sd100000, 16'd7, 0);
    run_div("pos/neg", 32'd100000, -16'sd7, 0);
    run_div("neg/neg", -32'sd100000, -16'sd7, 0);
    run_div("zero quotient", 32'd5, 16'd9, 0);
    run_div("zero dividend", 32'd0, 16'd5, 0);
    run_div("max quotient", 32'd98303, 16'd3, 0);
    run_div("first overflow", 32'd98304, 16'd3, 0);
    run_div("min divisor", 32'h3FFF_FFFF, 16'h8000, 0);
    run_div("min by minus one", 32'h8000_0000, 16'hFFFF, 0);
    run_div("large pos overflow", 32'h7FFF_FFFF, 16'd2, 0);
    run_trap(32'd12345);
    run_div("busy strobes", -32'sd77777, 16'd13, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R9 watchdog: got hang expected finish");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule